// File: doc/BRIEF.md
# Four-Lane Receive Sample Demapper

The block sits directly after a four-lane serial receive link layer. It turns the raw per-lane octet stream into converter samples. Each clock brings a 128-bit word made of four 32-bit lane slices. Inside each slice, two 16-bit sample words arrive with their first-received octet in the low byte. The demapper swaps the octets of each sample word so that the first-received octet becomes the most significant. It then splits every word into a 15-bit signed data value and a trailing control bit, and registers both.

The link runs with two converters, two octets per frame, two samples per converter per frame and sixteen frames per multiframe. Each lane therefore carries one sample per frame, and two frames per clock. Converter 0 owns lanes 0 and 1, and converter 1 owns lanes 2 and 3. Sample k = 2n + s is slot s (0 = earlier frame) of lane n. Start-of-frame and start-of-multiframe flags, one bit per frame slot, travel through the same single register stage as the data. An output valid strobe follows the input valid strobe. The output stage is cleared by the link layer's active-low reset, which is sampled synchronously.

Top module: `jesd_rx_demap`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `smp_valid_o`, `smp_sof_o`, `smp_somf_o`, `smp_data_o` and `smp_ctrl_o` all become zero.
- R2: `smp_valid_o` equals the value of `lnk_valid_i` at the previous rising edge.
- R3: For sample k (lane n = k/2, slot s = k%2), let `first` be input octet `lnk_data_i[16k+7:16k]` and `second` be `lnk_data_i[16k+15:16k+8]`. The sample word is {first, second}, and `smp_data_o[15k+14:15k]` becomes its upper 15 bits one clock after a valid beat.
- R4: `smp_ctrl_o[k]` becomes bit 0 of the sample word, which is `lnk_data_i[16k+8]`, one clock after a valid beat.
- R5: When `lnk_valid_i` is low, `smp_data_o` and `smp_ctrl_o` keep their previous values.
- R6: `smp_sof_o[s]` equals `lnk_sof_i[s] & lnk_valid_i` from the previous edge, so a flag on an invalid beat is dropped.
- R7: `smp_somf_o[s]` equals `lnk_somf_i[s] & lnk_valid_i` from the previous edge, with the same drop rule.
- R8: Each 15-bit data field is two's complement, and its top bit is the MSB of the first-received octet. A first octet of 0x80 followed by 0x01 therefore reads as -16384 with control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link-layer user clock |
| rst_n | input | 1 | Active-low reset from the link layer, sampled synchronously |
| lnk_data_i | input | 128 | Lane slices, lane n in bits [32n+31:32n], first octet lowest |
| lnk_valid_i | input | 1 | Input beat valid |
| lnk_sof_i | input | 2 | Start of frame, one bit per frame slot |
| lnk_somf_i | input | 2 | Start of multiframe, one bit per frame slot |
| smp_data_o | output | 120 | Eight signed 15-bit samples, sample k in [15k+14:15k] |
| smp_ctrl_o | output | 8 | Control bit of each sample |
| smp_valid_o | output | 1 | Output valid, one clock after input valid |
| smp_sof_o | output | 2 | Registered start-of-frame per slot |
| smp_somf_o | output | 2 | Registered start-of-multiframe per slot |

## Verification
The assertions assume that reset is applied at the first clock edge. They also assume that every input is driven to a known level at each edge once reset is released. The marker checks treat `lnk_sof_i` and `lnk_somf_i` as meaningful only on valid beats. The stimulus stays inside these assumptions: reset is held low from time zero, and every input is changed on the falling edge. It also includes beats where markers are raised while valid is low, so the drop rule is exercised.

// File: rtl/jesd_rx_demap_pkg.sv
package jesd_rx_demap_pkg;
  localparam int unsigned OCTET_W = 8;
endpackage

// File: rtl/jrd_lane_unpack.sv
module jrd_lane_unpack
  import jesd_rx_demap_pkg::*;
#(
  parameter int unsigned LANE_W   = 32,
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic [LANE_W-1:0]                              lane_i,
  output logic [(LANE_W/SAMPLE_W)*(SAMPLE_W-1)-1:0]      data_o,
  output logic [(LANE_W/SAMPLE_W)-1:0]                   ctrl_o
);
  localparam int unsigned SLOTS  = LANE_W / SAMPLE_W;
  localparam int unsigned OCTS   = SAMPLE_W / OCTET_W;
  localparam int unsigned DATA_W = SAMPLE_W - 1;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [SAMPLE_W-1:0] word;
    for (genvar o = 0; o < OCTS; o++) begin : g_oct
      // earliest octet on the wire lands in the most significant position
      assign word[SAMPLE_W-1-OCTET_W*o -: OCTET_W] = lane_i[s*SAMPLE_W + OCTET_W*o +: OCTET_W];
    end
    assign data_o[s*DATA_W +: DATA_W] = word[SAMPLE_W-1:1];
    assign ctrl_o[s]                  = word[0];
  end
endmodule

// File: rtl/jrd_flag_pipe.sv
module jrd_flag_pipe #(
  parameter int unsigned SLOTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [SLOTS-1:0] sof_i,
  input  logic [SLOTS-1:0] somf_i,
  output logic             valid_o,
  output logic [SLOTS-1:0] sof_o,
  output logic [SLOTS-1:0] somf_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      sof_o   <= '0;
      somf_o  <= '0;
    end else begin
      valid_o <= valid_i;
      sof_o   <= valid_i ? sof_i  : '0;
      somf_o  <= valid_i ? somf_i : '0;
    end
  end
endmodule

// File: rtl/jesd_rx_demap.sv
module jesd_rx_demap
  import jesd_rx_demap_pkg::*;
#(
  parameter int unsigned LANES        = 4,
  parameter int unsigned LANE_W       = 32,
  parameter int unsigned FRAME_OCTETS = 2
) (
  input  logic                                                             clk,
  input  logic                                                             rst_n,
  input  logic [LANES*LANE_W-1:0]                                          lnk_data_i,
  input  logic                                                             lnk_valid_i,
  input  logic [LANE_W/(FRAME_OCTETS*OCTET_W)-1:0]                         lnk_sof_i,
  input  logic [LANE_W/(FRAME_OCTETS*OCTET_W)-1:0]                         lnk_somf_i,
  output logic [LANES*(LANE_W/(FRAME_OCTETS*OCTET_W))*(FRAME_OCTETS*OCTET_W-1)-1:0] smp_data_o,
  output logic [LANES*(LANE_W/(FRAME_OCTETS*OCTET_W))-1:0]                 smp_ctrl_o,
  output logic                                                             smp_valid_o,
  output logic [LANE_W/(FRAME_OCTETS*OCTET_W)-1:0]                         smp_sof_o,
  output logic [LANE_W/(FRAME_OCTETS*OCTET_W)-1:0]                         smp_somf_o
);
  localparam int unsigned SAMPLE_W = FRAME_OCTETS * OCTET_W;
  localparam int unsigned SLOTS    = LANE_W / SAMPLE_W;
  localparam int unsigned DATA_W   = SAMPLE_W - 1;
  localparam int unsigned NSAMP    = LANES * SLOTS;

  logic [NSAMP*DATA_W-1:0] data_c;
  logic [NSAMP-1:0]        ctrl_c;

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    jrd_lane_unpack #(
      .LANE_W  (LANE_W),
      .SAMPLE_W(SAMPLE_W)
    ) u_unpack (
      .lane_i(lnk_data_i[n*LANE_W +: LANE_W]),
      .data_o(data_c[n*SLOTS*DATA_W +: SLOTS*DATA_W]),
      .ctrl_o(ctrl_c[n*SLOTS +: SLOTS])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_data_o <= '0;
      smp_ctrl_o <= '0;
    end else if (lnk_valid_i) begin
      smp_data_o <= data_c;
      smp_ctrl_o <= ctrl_c;
    end
  end

  jrd_flag_pipe #(.SLOTS(SLOTS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid_i(lnk_valid_i),
    .sof_i  (lnk_sof_i),
    .somf_i (lnk_somf_i),
    .valid_o(smp_valid_o),
    .sof_o  (smp_sof_o),
    .somf_o (smp_somf_o)
  );
endmodule

// File: rtl/jesd_rx_demap_chk.sv
module jesd_rx_demap_chk #(
  parameter int unsigned DW_IN  = 128,
  parameter int unsigned DW_OUT = 120,
  parameter int unsigned NSAMP  = 8,
  parameter int unsigned SLOTS  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DW_IN-1:0]  lnk_data_i,
  input logic              lnk_valid_i,
  input logic [SLOTS-1:0]  lnk_sof_i,
  input logic [SLOTS-1:0]  lnk_somf_i,
  input logic [DW_OUT-1:0] smp_data_o,
  input logic [NSAMP-1:0]  smp_ctrl_o,
  input logic              smp_valid_o,
  input logic [SLOTS-1:0]  smp_sof_o,
  input logic [SLOTS-1:0]  smp_somf_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!smp_valid_o && smp_sof_o == '0 && smp_somf_o == '0 && smp_ctrl_o == '0));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_valid_i |=> smp_valid_o);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lnk_valid_i |=> !smp_valid_o);

  // first sample: first octet of lane 0 forms the top eight data bits
  assert_first_octet_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_valid_i |=> smp_data_o[14:7] == $past(lnk_data_i[7:0]));

  assert_ctrl_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_valid_i |=> smp_ctrl_o[0] == $past(lnk_data_i[8]));

  assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lnk_valid_i |=> ($stable(smp_data_o) && $stable(smp_ctrl_o)));

  assert_sof_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lnk_valid_i |=> smp_sof_o == '0);

  assert_sof_passed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_valid_i |=> smp_sof_o == $past(lnk_sof_i));

  assert_somf_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lnk_valid_i |=> smp_somf_o == '0);

  assert_somf_passed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_valid_i |=> smp_somf_o == $past(lnk_somf_i));
endmodule

bind jesd_rx_demap jesd_rx_demap_chk #(
  .DW_IN (LANES*LANE_W),
  .DW_OUT(NSAMP*DATA_W),
  .NSAMP (NSAMP),
  .SLOTS (SLOTS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lnk_data_i (lnk_data_i),
  .lnk_valid_i(lnk_valid_i),
  .lnk_sof_i  (lnk_sof_i),
  .lnk_somf_i (lnk_somf_i),
  .smp_data_o (smp_data_o),
  .smp_ctrl_o (smp_ctrl_o),
  .smp_valid_o(smp_valid_o),
  .smp_sof_o  (smp_sof_o),
  .smp_somf_o (smp_somf_o)
);

// File: tb/jesd_rx_demap_tb.sv
`timescale 1ns/1ps
module jesd_rx_demap_tb;
  localparam int NS = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] lnk_data_i = '0;
  logic         lnk_valid_i = 1'b0;
  logic [1:0]   lnk_sof_i = '0;
  logic [1:0]   lnk_somf_i = '0;
  logic [119:0] smp_data_o;
  logic [7:0]   smp_ctrl_o;
  logic         smp_valid_o;
  logic [1:0]   smp_sof_o;
  logic [1:0]   smp_somf_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  jesd_rx_demap u_dut (
    .clk(clk), .rst_n(rst_n), .lnk_data_i(lnk_data_i), .lnk_valid_i(lnk_valid_i),
    .lnk_sof_i(lnk_sof_i), .lnk_somf_i(lnk_somf_i), .smp_data_o(smp_data_o),
    .smp_ctrl_o(smp_ctrl_o), .smp_valid_o(smp_valid_o), .smp_sof_o(smp_sof_o),
    .smp_somf_o(smp_somf_o)
  );

  localparam logic [127:0] VEC_D [8] = '{
    128'h00000000_00000000_00000000_00000000,
    128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
    128'h0F0E0D0C_0B0A0908_07060504_03020100,
    128'h01800180_01800180_01800180_01800180,
    128'hDEADBEEF_CAFEF00D_12345678_9ABCDEF0,
    128'h55AA55AA_AA55AA55_00FF00FF_FF00FF00,
    128'h80000000_00000080_7FFF0001_0100FF7F,
    128'h13579BDF_2468ACE0_FEDCBA98_76543210
  };
  localparam logic [1:0] VEC_SOF  [8] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b01, 2'b00, 2'b10, 2'b01};
  localparam logic [1:0] VEC_SOMF [8] = '{2'b00, 2'b00, 2'b01, 2'b10, 2'b11, 2'b01, 2'b00, 2'b10};

  // sample k uses bus octets 2k (first) and 2k+1 (second); word = {first, second}
  function automatic logic [119:0] exp_data(input logic [127:0] d);
    logic [119:0] r;
    for (int k = 0; k < NS; k++) begin
      logic [15:0] w;
      w = {d[16*k +: 8], d[16*k+8 +: 8]};
      r[15*k +: 15] = w[15:1];
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_ctrl(input logic [127:0] d);
    logic [7:0] r;
    for (int k = 0; k < NS; k++) r[k] = d[16*k+8];
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive on falling edge, sample shortly after the next rising edge
  task automatic beat(input logic [127:0] d, input logic v, input logic [1:0] sf, input logic [1:0] mf);
    @(negedge clk);
    lnk_data_i = d; lnk_valid_i = v; lnk_sof_i = sf; lnk_somf_i = mf;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [119:0] held_d;
    logic [7:0]   held_c;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid", 128'(smp_valid_o), 128'd0);
    chk("R1 data",  128'(smp_data_o), 128'd0);
    chk("R1 flags", 128'({smp_ctrl_o, smp_sof_o, smp_somf_o}), 128'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      beat(VEC_D[i], 1'b1, VEC_SOF[i], VEC_SOMF[i]);
      chk("R2 valid", 128'(smp_valid_o), 128'd1);
      chk("R3 data",  128'(smp_data_o), 128'(exp_data(VEC_D[i])));
      chk("R4 ctrl",  128'(smp_ctrl_o), 128'(exp_ctrl(VEC_D[i])));
      chk("R6 sof",   128'(smp_sof_o), 128'(VEC_SOF[i]));
      chk("R7 somf",  128'(smp_somf_o), 128'(VEC_SOMF[i]));
    end

    // R8: first octet 0x80, second 0x01 on every sample
    beat(VEC_D[3], 1'b1, 2'b00, 2'b00);
    for (int k = 0; k < NS; k++) begin
      chk("R8 signed value", 128'($signed(smp_data_o[15*k +: 15]) == -16384), 128'd1);
      chk("R8 ctrl", 128'(smp_ctrl_o[k]), 128'd1);
    end
    held_d = smp_data_o; held_c = smp_ctrl_o;

    // R5/R6/R7: invalid beat with new data and markers raised
    beat(VEC_D[4], 1'b0, 2'b11, 2'b11);
    chk("R2 valid low", 128'(smp_valid_o), 128'd0);
    chk("R5 data held", 128'(smp_data_o), 128'(held_d));
    chk("R5 ctrl held", 128'(smp_ctrl_o), 128'(held_c));
    chk("R6 sof dropped", 128'(smp_sof_o), 128'd0);
    chk("R7 somf dropped", 128'(smp_somf_o), 128'd0);
    beat(VEC_D[5], 1'b0, 2'b01, 2'b10);
    chk("R5 data held again", 128'(smp_data_o), 128'(held_d));

    // R2: valid returns, data updates
    beat(VEC_D[6], 1'b1, 2'b10, 2'b01);
    chk("R2 valid back", 128'(smp_valid_o), 128'd1);
    chk("R3 data after idle", 128'(smp_data_o), 128'(exp_data(VEC_D[6])));
    chk("R4 ctrl after idle", 128'(smp_ctrl_o), 128'(exp_ctrl(VEC_D[6])));

    // R1: reset mid-stream while valid with markers
    @(negedge clk);
    rst_n = 1'b0; lnk_data_i = VEC_D[1]; lnk_valid_i = 1'b1; lnk_sof_i = 2'b11; lnk_somf_i = 2'b11;
    @(posedge clk); #1;
    chk("R1 valid mid", 128'(smp_valid_o), 128'd0);
    chk("R1 data mid",  128'(smp_data_o), 128'd0);
    chk("R1 flags mid", 128'({smp_ctrl_o, smp_sof_o, smp_somf_o}), 128'd0);
    @(negedge clk); rst_n = 1'b1; lnk_valid_i = 1'b0;
    @(posedge clk); #1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule